// File: doc/BRIEF.md
# FPGA SPI Configuration Loader Sequencer

This block loads a configuration bitstream into a target FPGA through the target's SPI configuration port. It drives the target's active-low configuration reset, an active-low chip select, the serial clock and the controller-out data line. It also watches the target's configuration-done output. Bitstream bytes come in on a valid/ready byte stream that carries a marker on the last byte. The block does not store the bitstream.

A one-cycle start pulse in idle launches a fixed sequence. The block first pulses configuration reset low for a minimum width. It then waits long enough for the target to clear its configuration memory. Next it sends dummy clocks with chip select high, and then the bitstream with chip select low, most significant bit first. After the last byte it sends more dummy clocks with chip select high. Finally it samples configuration-done and sets either a done flag or an error flag.

Every delay is a parameter in microseconds, turned into cycles through a clock-frequency parameter in MHz. The serial clock is a square wave whose half period is a parameter in clock cycles. The default half period gives about 1 MHz at the default clock.

Top module: `cfg_loader_top`

## Requirements
- R1: After reset and whenever idle: creset_n_o=1, cs_n_o=1, sck_o=0, busy_o=0 and in_ready_o=0.
- R2: A start_i pulse in idle raises busy_o and clears done_o and err_o. It drives creset_n_o low for exactly max(RST_US*CLK_MHZ, ceil(CLK_MHZ/5), 1) cycles, which is never shorter than 200 ns.
- R3: After creset_n_o returns high, at least CLR_US*CLK_MHZ cycles pass before the first sck_o rising edge. While configuration reset is low, cs_n_o stays high and sck_o stays low.
- R4: Exactly LEAD_CLKS rising edges of sck_o occur with cs_n_o high before the first bitstream bit.
- R5: Each accepted byte is sent as 8 rising edges of sck_o with cs_n_o low. Bit 7 goes first, and mosi_o is the bit value at each rising edge. mosi_o and cs_n_o change only while sck_o is low.
- R6: Every high phase of sck_o lasts exactly HALF_CYC clock cycles.
- R7: in_ready_o is high only between bytes of the transfer, with cs_n_o low and sck_o low. A byte is taken when in_valid_i and in_ready_o are both high, and gaps of any length between bytes are allowed.
- R8: After the byte marked by in_last_i, cs_n_o returns high and exactly TRAIL_CLKS rising edges of sck_o follow.
- R9: After the trailing clocks, the synchronized cfg_done_i decides the outcome: 1 sets done_o and 0 sets err_o, and busy_o falls. The flags are never both high and hold until the next accepted start.
- R10: A start_i pulse while busy_o is high is ignored. No second reset pulse occurs and the running transfer is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, acted on only when idle |
| in_valid_i | input | 1 | Bitstream byte valid |
| in_data_i | input | 8 | Bitstream byte |
| in_last_i | input | 1 | Marks the final bitstream byte |
| in_ready_o | output | 1 | Block accepts a byte this cycle |
| creset_n_o | output | 1 | Target configuration reset, active low |
| cs_n_o | output | 1 | Target chip select, active low |
| sck_o | output | 1 | Serial clock to target |
| mosi_o | output | 1 | Serial data to target |
| cfg_done_i | input | 1 | Configuration-done from target (asynchronous) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last load succeeded |
| err_o | output | 1 | Last load ended without configuration-done |

## Verification
The assertions assume that start_i, in_valid_i, in_data_i and in_last_i are synchronous to clk_i. They also assume that in_valid_i is never dropped by the source while it waits, and that cfg_done_i is steady before the trailing clocks end. The bench changes its inputs only at falling clock edges. It holds each byte valid until the byte is taken, and it sets cfg_done_i before each run starts. Random byte values, gap lengths, run lengths and outcomes stay inside these limits. Start pulses injected during a busy run test R10.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_CLR,
        ST_LEAD,
        ST_WAIT,
        ST_SHIFT,
        ST_TRAIL,
        ST_CHECK
    } ld_state_e;

endpackage

// File: rtl/cfg_ld_timer.sv
module cfg_ld_timer #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = value_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R2: a loaded count never lands above the loaded value
    a_r2_timer_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (cnt_q == $past(value_i)));
endmodule

// File: rtl/cfg_ld_sclk.sv
module cfg_ld_sclk #(
    parameter int HALF_CYC = 125
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic sck_o,
    output logic pulse_end_o
);
    localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [HW-1:0] HC_LAST = HW'(HALF_CYC - 1);

    typedef struct packed {
        logic          ph;
        logic [HW-1:0] hc;
    } sclk_reg_t;

    sclk_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!run_i) begin
            r_d = '0;
        end else if (r_q.hc == HC_LAST) begin
            r_d.hc = '0;
            r_d.ph = ~r_q.ph;
        end else begin
            r_d.hc = r_q.hc + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) r_q <= '0;
        else       r_q <= r_d;
    end

    assign sck_o       = r_q.ph;
    assign pulse_end_o = run_i && r_q.ph && (r_q.hc == HC_LAST);

    // R6: the clock only rises out of a stopped or low state with the phase counter at zero
    a_r6_rise_fresh: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sck_o) |-> (r_q.hc == '0));
endmodule

// File: rtl/cfg_loader_top.sv
module cfg_loader_top
    import cfg_ld_pkg::*;
#(
    parameter int CLK_MHZ    = 250,
    parameter int RST_US     = 1,
    parameter int CLR_US     = 1200,
    parameter int LEAD_CLKS  = 8,
    parameter int TRAIL_CLKS = 49,
    parameter int HALF_CYC   = 125
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       start_i,
    input  logic       in_valid_i,
    input  logic [7:0] in_data_i,
    input  logic       in_last_i,
    output logic       in_ready_o,
    output logic       creset_n_o,
    output logic       cs_n_o,
    output logic       sck_o,
    output logic       mosi_o,
    input  logic       cfg_done_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);
    // delays in cycles; the reset pulse never drops below 200 ns
    localparam int RST_REQ = RST_US * CLK_MHZ;
    localparam int RST_MIN = ((CLK_MHZ + 4) / 5 > 0) ? (CLK_MHZ + 4) / 5 : 1;
    localparam int RST_CYC = (RST_REQ > RST_MIN) ? RST_REQ : RST_MIN;
    localparam int CLR_REQ = CLR_US * CLK_MHZ;
    localparam int CLR_CYC = (CLR_REQ > 0) ? CLR_REQ : 1;
    localparam int TMAX    = (RST_CYC > CLR_CYC) ? RST_CYC : CLR_CYC;
    localparam int TW      = $clog2(TMAX + 1);
    localparam int PMAX    = (LEAD_CLKS > TRAIL_CLKS) ? LEAD_CLKS : TRAIL_CLKS;
    localparam int PW      = $clog2(PMAX + 1);
    localparam logic [PW-1:0] LEAD_LAST  = PW'(LEAD_CLKS - 1);
    localparam logic [PW-1:0] TRAIL_LAST = PW'(TRAIL_CLKS - 1);

    typedef struct packed {
        ld_state_e     st;
        logic          cr_n;
        logic          cs_n;
        logic [7:0]    sh;
        logic [2:0]    bc;
        logic          last;
        logic [PW-1:0] pc;
        logic [1:0]    dsync;
        logic          done;
        logic          err;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    logic          t_load;
    logic [TW-1:0] t_val;
    logic          t_exp;
    logic          run;
    logic          pulse_end;

    cfg_ld_timer #(.W(TW)) timer_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .load_i    (t_load),
        .value_i   (t_val),
        .expired_o (t_exp)
    );

    assign run = (r_q.st == ST_LEAD) || (r_q.st == ST_SHIFT) || (r_q.st == ST_TRAIL);

    cfg_ld_sclk #(.HALF_CYC(HALF_CYC)) sclk_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .run_i       (run),
        .sck_o       (sck_o),
        .pulse_end_o (pulse_end)
    );

    always_comb begin
        r_d       = r_q;
        r_d.dsync = {r_q.dsync[0], cfg_done_i};
        t_load    = 1'b0;
        t_val     = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_RST;
                    r_d.cr_n = 1'b0;
                    r_d.done = 1'b0;
                    r_d.err  = 1'b0;
                    t_load   = 1'b1;
                    t_val    = TW'(RST_CYC - 1);
                end
            end
            ST_RST: begin
                if (t_exp) begin
                    r_d.st   = ST_CLR;
                    r_d.cr_n = 1'b1;
                    t_load   = 1'b1;
                    t_val    = TW'(CLR_CYC - 1);
                end
            end
            ST_CLR: begin
                if (t_exp) begin
                    r_d.st = ST_LEAD;
                    r_d.pc = '0;
                end
            end
            ST_LEAD: begin
                if (pulse_end) begin
                    if (r_q.pc == LEAD_LAST) begin
                        r_d.st   = ST_WAIT;
                        r_d.cs_n = 1'b0;
                        r_d.pc   = '0;
                    end else begin
                        r_d.pc = r_q.pc + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (in_valid_i) begin
                    r_d.st   = ST_SHIFT;
                    r_d.sh   = in_data_i;
                    r_d.last = in_last_i;
                    r_d.bc   = '0;
                end
            end
            ST_SHIFT: begin
                if (pulse_end) begin
                    r_d.sh = {r_q.sh[6:0], 1'b0};
                    r_d.bc = r_q.bc + 1'b1;
                    if (r_q.bc == 3'd7) begin
                        if (r_q.last) begin
                            r_d.st   = ST_TRAIL;
                            r_d.cs_n = 1'b1;
                            r_d.pc   = '0;
                        end else begin
                            r_d.st = ST_WAIT;
                        end
                    end
                end
            end
            ST_TRAIL: begin
                if (pulse_end) begin
                    if (r_q.pc == TRAIL_LAST) r_d.st = ST_CHECK;
                    else                      r_d.pc = r_q.pc + 1'b1;
                end
            end
            ST_CHECK: begin
                r_d.st   = ST_IDLE;
                r_d.done = r_q.dsync[1];
                r_d.err  = ~r_q.dsync[1];
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.cr_n <= 1'b1;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready_o = (r_q.st == ST_WAIT);
    assign creset_n_o = r_q.cr_n;
    assign cs_n_o     = r_q.cs_n;
    assign mosi_o     = r_q.sh[7];
    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = r_q.done;
    assign err_o      = r_q.err;

    // R1: idle lines
    a_r1_idle_lines: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> (cs_n_o && !sck_o && creset_n_o && !in_ready_o));
    // R2: reset pulse begins only from an idle start
    a_r2_reset_origin: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(creset_n_o) |-> ($past(start_i) && !$past(busy_o)));
    // R3: target held quiet while in reset
    a_r3_quiet_in_reset: assert property (@(posedge clk_i) disable iff (rst_i)
        !creset_n_o |-> (cs_n_o && !sck_o));
    // R5: data held while clock high
    a_r5_data_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));
    // R5: chip select never moves with a rising clock
    a_r5_cs_at_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sck_o) |-> $stable(cs_n_o));
    // R7: ready only inside the transfer with clock low
    a_r7_ready_window: assert property (@(posedge clk_i) disable iff (rst_i)
        in_ready_o |-> (!cs_n_o && !sck_o));
    // R9: outcome flags exclusive and only when idle
    a_r9_flags_excl: assert property (@(posedge clk_i) disable iff (rst_i)
        !(done_o && err_o));
    a_r9_flags_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o || err_o) |-> !busy_o);
    // R10: start while busy starts nothing
    a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && start_i) |=> !$fell(creset_n_o));
endmodule

// File: tb/cfg_loader_top_tb_top.sv
module cfg_loader_top_tb_top;
    localparam int CLK_MHZ    = 250;
    localparam int RST_US     = 1;
    localparam int CLR_US     = 2;
    localparam int LEAD_CLKS  = 8;
    localparam int TRAIL_CLKS = 49;
    localparam int HALF_CYC   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_last = 1'b0;
    logic cfg_done = 1'b0;
    logic in_ready, creset_n, cs_n, sck, mosi, busy, done, err;

    always #2 clk = ~clk;

    cfg_loader_top #(
        .CLK_MHZ(CLK_MHZ), .RST_US(RST_US), .CLR_US(CLR_US),
        .LEAD_CLKS(LEAD_CLKS), .TRAIL_CLKS(TRAIL_CLKS), .HALF_CYC(HALF_CYC)
    ) dut_i (
        .clk_i(clk), .rst_i(rst), .start_i(start),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
        .in_ready_o(in_ready), .creset_n_o(creset_n), .cs_n_o(cs_n),
        .sck_o(sck), .mosi_o(mosi), .cfg_done_i(cfg_done),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_rst_cycles();
        int req = RST_US * CLK_MHZ;
        int mn  = (CLK_MHZ + 4) / 5;
        if (mn < 1) mn = 1;
        return (req > mn) ? req : mn;
    endfunction

    // port monitor
    int lead_n, trail_n, bits_n, got_n, lo_run, lo_len, falls, gap_run, gap_len, hi_run;
    bit gap_armed, hi_bad, rdy_bad;
    logic [7:0] cur;
    logic [7:0] got [16];
    logic prev_sck = 1'b0;
    logic prev_cr = 1'b1;

    task automatic clear_mon();
        lead_n = 0; trail_n = 0; bits_n = 0; got_n = 0; lo_run = 0; lo_len = 0;
        falls = 0; gap_run = 0; gap_len = -1; hi_run = 0;
        gap_armed = 1'b0; hi_bad = 1'b0; rdy_bad = 1'b0; cur = 8'h00;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!creset_n && prev_cr) falls++;
            if (!creset_n) lo_run++;
            else if (!prev_cr) begin
                lo_len = lo_run; lo_run = 0; gap_armed = 1'b1; gap_run = 0;
            end
            if (gap_armed) begin
                if (sck) begin gap_len = gap_run; gap_armed = 1'b0; end
                else gap_run++;
            end
            if (sck && !prev_sck) begin
                if (cs_n) begin
                    if (bits_n == 0) lead_n++; else trail_n++;
                end else begin
                    cur = {cur[6:0], mosi};
                    bits_n++;
                    if (bits_n % 8 == 0 && got_n < 16) begin got[got_n] = cur; got_n++; end
                end
            end
            if (sck) hi_run++;
            else if (prev_sck) begin
                if (hi_run != HALF_CYC) hi_bad = 1'b1;
                hi_run = 0;
            end
            if (in_ready && (cs_n || sck)) rdy_bad = 1'b1;
            prev_sck = sck;
            prev_cr  = creset_n;
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic l);
        in_valid = 1'b1; in_data = b; in_last = l;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_data = $urandom;
    endtask

    task automatic run(input int nb, input bit dv, input bit poke, input bit first);
        logic [7:0] exp_b [16];
        int bad_idx;
        bit d0, e0;
        for (int i = 0; i < nb; i++) exp_b[i] = 8'($urandom);
        @(negedge clk);
        clear_mon();
        cfg_done = dv;
        pulse_start();
        if (!first) chk(busy && !done && !err, "R2 start clears flags", {29'd0, busy, done, err}, 4);
        if (poke) begin
            repeat (5) @(negedge clk);
            pulse_start();
        end
        for (int i = 0; i < nb; i++) begin
            repeat ($urandom % 4) @(negedge clk);
            if (poke && i == 0) pulse_start();
            send_byte(exp_b[i], i == nb - 1);
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(lo_len == exp_rst_cycles(), "R2 reset width", lo_len, exp_rst_cycles());
        chk(falls == 1, "R10 one reset pulse", falls, 1);
        chk(gap_len >= CLR_US * CLK_MHZ, "R3 clear wait", gap_len, CLR_US * CLK_MHZ);
        chk(lead_n == LEAD_CLKS, "R4 leading clocks", lead_n, LEAD_CLKS);
        chk(got_n == nb, "R5 byte count", got_n, nb);
        bad_idx = -1;
        for (int i = 0; i < nb; i++)
            if (bad_idx < 0 && got[i] !== exp_b[i]) bad_idx = i;
        if (bad_idx < 0) chk(1'b1, "R5 byte data", 0, 0);
        else chk(1'b0, "R5 byte data", int'(got[bad_idx]), int'(exp_b[bad_idx]));
        chk(!hi_bad, "R6 high phase width", int'(hi_bad), 0);
        chk(!rdy_bad, "R7 ready window", int'(rdy_bad), 0);
        chk(trail_n == TRAIL_CLKS, "R8 trailing clocks", trail_n, TRAIL_CLKS);
        chk(done == dv && err == !dv, "R9 outcome", {30'd0, done, err}, dv ? 2 : 1);
        d0 = done; e0 = err;
        cfg_done = !dv;
        repeat (10) @(negedge clk);
        chk(done == d0 && err == e0 && !busy, "R9 flags hold", {30'd0, done, err}, {30'd0, d0, e0});
        chk(cs_n && !sck && creset_n && !in_ready, "R1 idle after run",
            {28'd0, cs_n, sck, creset_n, in_ready}, 4'b1010);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_C0DE);
        clear_mon();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(creset_n && cs_n && !sck && !busy && !in_ready && !done && !err, "R1 reset state",
            {25'd0, creset_n, cs_n, sck, busy, in_ready, done, err}, 7'b1100000);
        run(1, 1'b1, 1'b0, 1'b1);
        run(16, 1'b0, 1'b1, 1'b0);
        for (int k = 0; k < 5; k++)
            run(1 + ($urandom % 16), 1'(($urandom % 2)), 1'(($urandom % 2)), 1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule